// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts, for a fetch unit that reads code in 16-byte blocks, whether the current fetch block holds a taken branch, where it sits within the block and where it goes. Every cycle the fetch address is split into a byte position within the block, a set number and a tag. All four ways of the selected set are read in parallel, in the same cycle, with no register in the path.

Several ways of one set may hold the same tag, one per branch of the same block, because each entry also records the byte position of its branch. A selection rule picks the first branch at or after the current fetch position. Resolved branches arrive on an update port. An update either refreshes an existing entry in place or allocates a new way, preferring an empty way and otherwise evicting the tree pseudo-LRU victim. A separate port flags a predicted location that proved not to be a branch, and the whole set holding it is then emptied.

Top module: `btb_top`

## Requirements
- R1: Address bits [3:0] are the byte position, bits [12:4] the set (512 sets of 4 ways) and bits [21:13] the tag. A lookup hits only on a valid entry of the addressed set whose stored tag equals the fetch tag. Bits above 21 are ignored.
- R2: The lookup outputs follow the fetch address in the same cycle. An update or invalidation becomes visible on lookups only after the next rising clock edge.
- R3: Among the hitting ways, the one with the smallest stored position that is not below the fetch position is reported, with its target and its position on `hit_offset`. If every tag-matching way lies below the fetch position, `hit` is 0.
- R4: Branches with the same tag but different positions occupy separate ways and can all be predicted. A new entry goes into the lowest-numbered invalid way of its set.
- R5: When the set is full, the new entry replaces the victim of a per-set 3-bit tree. The root selects a half: 0 picks ways 0/1, 1 picks ways 2/3. The left-pair bit picks way 0 when 0 and way 1 when 1. The right-pair bit picks way 2 when 0 and way 3 when 1. Writing a way points every bit on its path away from it. All trees are zero after reset.
- R6: An update whose tag and position match a valid entry rewrites that entry's target in place without taking another way. It counts as a use of that way for R5.
- R7: A bogus report invalidates all four ways of its set, and other sets are unaffected. If an update targets the same set in the same cycle, the update is dropped. An update to a different set still takes effect.
- R8: With `rst_n` low at a rising edge, every entry becomes invalid, so all later lookups miss until new updates arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 32 | Address of the current fetch |
| hit | output | 1 | A predicted branch lies at or after the fetch position |
| hit_target | output | 32 | Predicted target, zero when no hit |
| hit_offset | output | 4 | Byte position of the predicted branch, zero when no hit |
| upd_valid | input | 1 | Resolved branch to record this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Target of the resolved branch |
| bogus_valid | input | 1 | Predicted location was not a branch |
| bogus_addr | input | 32 | Address whose set is to be emptied |

## Verification
Lookup results are due in the same cycle as the fetch address. The bench therefore drives every input just after a falling edge and samples the outputs one nanosecond later, before the next rising edge. Update and bogus effects are due only after the following rising edge, so they are looked for on the lookup after that edge. One directed check samples the same address while its update is still pending, to confirm it is not yet visible. A randomized stream confined to two sets and six tags is also compared every cycle against a behavioural model built from the requirements.

// File: rtl/btb_pkg.sv
// Shared definitions for the branch target buffer: way count and the
// 4-way tree pseudo-LRU encoding. Assumes exactly four ways per set.
package btb_pkg;

    localparam int BTB_WAYS = 4;

    // bit 0: root (0 = left pair), bit 1: left pair (0 = way0), bit 2: right pair (0 = way2)
    typedef logic [2:0] plru_tree_t;

    // Way to evict according to a tree state.
    function automatic logic [1:0] plru_victim(input plru_tree_t t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    // Tree state after using way w: every node on w's path points away.
    function automatic plru_tree_t plru_touch(input plru_tree_t t, input logic [1:0] w);
        plru_tree_t n;
        n = t;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction

endpackage

// File: rtl/btb_way_store.sv
// One way of the buffer: valid, tag, position and target for every set.
// Two asynchronous read ports (fetch and update set). One write port at
// the update set, and one set-clear port. Clear wins over write to the
// same set. Assumes the caller never writes and clears one set together.
module btb_way_store #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 9,
    parameter int OFS_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [OFS_W-1:0]  rd_off,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic [IDX_W-1:0]  up_idx,
    output logic              up_valid,
    output logic [TAG_W-1:0]  up_tag,
    output logic [OFS_W-1:0]  up_off,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [OFS_W-1:0]  wr_off,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   v_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [OFS_W-1:0]  off_q [SETS];
    logic [ADDR_W-1:0] tgt_q [SETS];

    // Valid bits: cleared by reset, set by a write, dropped by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            if (wr_en)  v_q[up_idx]  <= 1'b1;
            if (clr_en) v_q[clr_idx] <= 1'b0;
        end
    end

    // Entry payload: written on update, no reset needed behind valid.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[up_idx] <= wr_tag;
            off_q[up_idx] <= wr_off;
            tgt_q[up_idx] <= wr_tgt;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_valid = v_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_off   = off_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        up_valid = v_q[up_idx];
        up_tag   = tag_q[up_idx];
        up_off   = off_q[up_idx];
    end

    // R7: a cleared set is empty on the following cycle.
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !v_q[$past(clr_idx)]);

    // R4: a write without a clash leaves the entry valid.
    p_write_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(clr_en && clr_idx == up_idx)) |=> v_q[$past(up_idx)]);

endmodule

// File: rtl/btb_hit_select.sv
// Chooses among tag-matching ways of one set: the smallest stored
// position not below the fetch position. Lowest way wins a tie.
// Assumes cand already folds in valid and tag equality.
module btb_hit_select #(
    parameter int WAYS  = 4,
    parameter int OFS_W = 4,
    localparam int SEL_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            cand,
    input  logic [WAYS-1:0][OFS_W-1:0] offs,
    input  logic [OFS_W-1:0]           fetch_off,
    output logic                       hit,
    output logic [SEL_W-1:0]           sel_idx
);
    logic [OFS_W-1:0] best;

    // Linear scan keeping the closest branch at or after fetch_off.
    always_comb begin
        hit     = 1'b0;
        best    = '1;
        sel_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && offs[w] >= fetch_off && (!hit || offs[w] < best)) begin
                hit     = 1'b1;
                best    = offs[w];
                sel_idx = SEL_W'(w);
            end
        end
    end

    // R3: any eligible way forces a hit no farther than that way.
    for (genvar g = 0; g < WAYS; g++) begin : g_min_chk
        p_nearest_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cand[g] && offs[g] >= fetch_off) |-> (hit && offs[sel_idx] <= offs[g]));
    end

endmodule

// File: rtl/btb_plru.sv
// Per-set 4-way tree pseudo-LRU state. Reports the victim of one queried
// set and applies a use of one way at the clock edge. Zero after reset.
module btb_plru #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] q_idx,
    output logic [1:0]       victim,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [1:0]       touch_way
);
    import btb_pkg::*;

    localparam int SETS = 1 << IDX_W;

    plru_tree_t trees_q [SETS];

    // Tree state: cleared on reset, moved away from a used way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) trees_q[s] <= '0;
        end else if (touch_en) begin
            trees_q[touch_idx] <= plru_touch(trees_q[touch_idx], touch_way);
        end
    end

    // Victim lookup for the update set.
    always_comb victim = plru_victim(trees_q[q_idx]);

    // R5: a way just used is never the next victim of its set.
    p_used_not_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> plru_victim(trees_q[$past(touch_idx)]) != $past(touch_way));

endmodule

// File: rtl/btb_top.sv
// Set-associative branch target buffer, 4 ways. Lookup is combinational
// from the way arrays. Update and bogus-hit invalidation act at the next
// edge. A bogus report wins over an update to the same set.
module btb_top #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4,
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_target,
    output logic [OFS_W-1:0]  hit_offset,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              bogus_valid,
    input  logic [ADDR_W-1:0] bogus_addr
);
    import btb_pkg::*;

    localparam int WAYS    = BTB_WAYS;
    localparam int SEL_W   = $clog2(WAYS);
    localparam int IDX_LSB = OFS_W;
    localparam int TAG_LSB = OFS_W + IDX_W;

    logic [IDX_W-1:0] f_idx, u_idx, b_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic [OFS_W-1:0] f_off, u_off;

    // Address field split for the three ports.
    always_comb begin
        f_off = fetch_addr[OFS_W-1:0];
        f_idx = fetch_addr[IDX_LSB +: IDX_W];
        f_tag = fetch_addr[TAG_LSB +: TAG_W];
        u_off = upd_addr[OFS_W-1:0];
        u_idx = upd_addr[IDX_LSB +: IDX_W];
        u_tag = upd_addr[TAG_LSB +: TAG_W];
        b_idx = bogus_addr[IDX_LSB +: IDX_W];
    end

    logic [WAYS-1:0]             rd_valid, up_valid, wr_en;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag, up_tag;
    logic [WAYS-1:0][OFS_W-1:0]  rd_off, up_off;
    logic [WAYS-1:0][ADDR_W-1:0] rd_tgt;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way_store #(
            .IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (f_idx),
            .rd_valid (rd_valid[w]),
            .rd_tag   (rd_tag[w]),
            .rd_off   (rd_off[w]),
            .rd_tgt   (rd_tgt[w]),
            .up_idx   (u_idx),
            .up_valid (up_valid[w]),
            .up_tag   (up_tag[w]),
            .up_off   (up_off[w]),
            .wr_en    (wr_en[w]),
            .wr_tag   (u_tag),
            .wr_off   (u_off),
            .wr_tgt   (upd_target),
            .clr_en   (bogus_valid),
            .clr_idx  (b_idx)
        );
    end

    // Lookup: tag-matching ways of the fetch set feed the selector.
    logic [WAYS-1:0]  cand;
    logic             sel_hit;
    logic [SEL_W-1:0] sel_idx;

    always_comb begin
        for (int w = 0; w < WAYS; w++) cand[w] = rd_valid[w] && (rd_tag[w] == f_tag);
    end

    btb_hit_select #(.WAYS(WAYS), .OFS_W(OFS_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand      (cand),
        .offs      (rd_off),
        .fetch_off (f_off),
        .hit       (sel_hit),
        .sel_idx   (sel_idx)
    );

    // Output mux, forced to zero on a miss.
    always_comb begin
        hit        = sel_hit;
        hit_target = sel_hit ? rd_tgt[sel_idx] : '0;
        hit_offset = sel_hit ? rd_off[sel_idx] : '0;
    end

    // Update: refresh a match, else lowest invalid way, else tree victim.
    logic [1:0]       victim;
    logic [SEL_W-1:0] wr_way;
    logic             have_match, have_free, upd_go;

    always_comb begin
        have_match = 1'b0;
        have_free  = 1'b0;
        wr_way     = victim;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!up_valid[w] && !have_match) begin
                have_free = 1'b1;
                wr_way    = SEL_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (up_valid[w] && up_tag[w] == u_tag && up_off[w] == u_off) begin
                have_match = 1'b1;
                wr_way     = SEL_W'(w);
            end
        end
        upd_go = upd_valid && !(bogus_valid && b_idx == u_idx);
        for (int w = 0; w < WAYS; w++) wr_en[w] = upd_go && (wr_way == SEL_W'(w));
    end

    btb_plru #(.IDX_W(IDX_W)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_idx     (u_idx),
        .victim    (victim),
        .touch_en  (upd_go),
        .touch_idx (u_idx),
        .touch_way (wr_way)
    );

    // R3: a reported branch never lies before the fetch position.
    p_hit_not_behind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_offset >= f_off);

    // R7: a same-set update beside a bogus report writes no way.
    p_bogus_blocks_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bogus_valid && upd_valid && b_idx == u_idx) |-> wr_en == '0);

endmodule

// File: tb/btb_top_tb.sv
`timescale 1ns/1ps
module btb_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        hit;
    logic [31:0] hit_target;
    logic [3:0]  hit_offset;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [31:0] upd_target = '0;
    logic        bogus_valid = 1'b0;
    logic [31:0] bogus_addr = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    btb_top u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
        .hit(hit), .hit_target(hit_target), .hit_offset(hit_offset),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
        .bogus_valid(bogus_valid), .bogus_addr(bogus_addr)
    );

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return (32'(tag) << 13) | (32'(idx) << 4) | 32'(off);
    endfunction

    // Compare sampled outputs against expectations.
    task automatic expect_out(input string req, input bit eh, input logic [31:0] et, input logic [3:0] eo);
        n_cmp++;
        if (hit !== eh || (eh && (hit_target !== et || hit_offset !== eo))) begin
            n_bad++;
            $display("FAIL %s addr=%h: got hit=%b tgt=%h off=%0d, expected hit=%b tgt=%h off=%0d",
                     req, fetch_addr, hit, hit_target, hit_offset, eh, et, eo);
        end
    endtask

    task automatic look(input logic [31:0] a, input string req, input bit eh,
                        input logic [31:0] et, input logic [3:0] eo);
        @(negedge clk);
        fetch_addr = a;
        #1;
        expect_out(req, eh, et, eo);
    endtask

    task automatic upd(input logic [31:0] a, input logic [31:0] t);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_target = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- behavioural model ----------------
    bit          m_v   [512][4];
    int          m_tag [512][4];
    int          m_off [512][4];
    logic [31:0] m_tgt [512][4];
    bit [2:0]    m_tr  [512];

    task automatic m_clear();
        for (int s = 0; s < 512; s++) begin
            m_tr[s] = '0;
            for (int w = 0; w < 4; w++) m_v[s][w] = 0;
        end
    endtask

    task automatic m_look(input logic [31:0] a, output bit h, output logic [31:0] t, output logic [3:0] o);
        int s = int'(a[12:4]);
        int tg = int'(a[21:13]);
        int fo = int'(a[3:0]);
        int best = 99;
        h = 0; t = '0; o = '0;
        for (int w = 0; w < 4; w++)
            if (m_v[s][w] && m_tag[s][w] == tg && m_off[s][w] >= fo && m_off[s][w] < best) begin
                best = m_off[s][w]; h = 1; t = m_tgt[s][w]; o = 4'(best);
            end
    endtask

    task automatic m_update(input logic [31:0] a, input logic [31:0] tgt);
        int s = int'(a[12:4]);
        int tg = int'(a[21:13]);
        int fo = int'(a[3:0]);
        int way = -1;
        for (int w = 0; w < 4; w++)
            if (way < 0 && m_v[s][w] && m_tag[s][w] == tg && m_off[s][w] == fo) way = w;
        for (int w = 0; w < 4; w++)
            if (way < 0 && !m_v[s][w]) way = w;
        if (way < 0) way = m_tr[s][0] ? 2 + int'(m_tr[s][2]) : int'(m_tr[s][1]);
        m_v[s][way] = 1; m_tag[s][way] = tg; m_off[s][way] = fo; m_tgt[s][way] = tgt;
        case (way)
            0: begin m_tr[s][0] = 1; m_tr[s][1] = 1; end
            1: begin m_tr[s][0] = 1; m_tr[s][1] = 0; end
            2: begin m_tr[s][0] = 0; m_tr[s][2] = 1; end
            default: begin m_tr[s][0] = 0; m_tr[s][2] = 0; end
        endcase
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        look(mk(0, 0, 0), "R8 reset", 0, '0, '0);
        look(mk(5, 300, 7), "R8 reset", 0, '0, '0);
    endtask

    task automatic t_basic();
        // R2: update pending before its edge is not yet visible.
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = mk(2, 80, 5); upd_target = 32'hA000_0010;
        fetch_addr = mk(2, 80, 0);
        #1; expect_out("R2 before edge", 0, '0, '0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1; expect_out("R2 after edge", 1, 32'hA000_0010, 4'd5);
        look(mk(2, 80, 5), "R3 equal position", 1, 32'hA000_0010, 4'd5);
        look(mk(2, 80, 6), "R3 behind fetch", 0, '0, '0);
        look(mk(3, 80, 0), "R1 other tag", 0, '0, '0);
        look(mk(2, 81, 0), "R1 other set", 0, '0, '0);
        look(mk(2, 80, 0) | 32'hFFC0_0000, "R1 high bits ignored", 1, 32'hA000_0010, 4'd5);
    endtask

    task automatic t_multi();
        upd(mk(3, 20, 2),  32'hB000_0002);
        upd(mk(3, 20, 9),  32'hB000_0009);
        upd(mk(3, 20, 13), 32'hB000_000D);
        look(mk(3, 20, 0),  "R4 first branch", 1, 32'hB000_0002, 4'd2);
        look(mk(3, 20, 3),  "R3 next branch", 1, 32'hB000_0009, 4'd9);
        look(mk(3, 20, 10), "R3 last branch", 1, 32'hB000_000D, 4'd13);
        look(mk(3, 20, 14), "R3 none ahead", 0, '0, '0);
    endtask

    task automatic t_plru();
        for (int k = 1; k <= 4; k++) upd(mk(k, 40, 0), 32'hC000_0000 + 32'(k));
        upd(mk(5, 40, 0), 32'hC000_0005);
        look(mk(1, 40, 0), "R5 way0 evicted", 0, '0, '0);
        look(mk(3, 40, 0), "R5 way2 kept", 1, 32'hC000_0003, 4'd0);
        upd(mk(3, 40, 0), 32'hCC00_0003);
        upd(mk(6, 40, 0), 32'hC000_0006);
        look(mk(2, 40, 0), "R6 refresh moves victim", 0, '0, '0);
        look(mk(3, 40, 0), "R6 target rewritten", 1, 32'hCC00_0003, 4'd0);
        look(mk(4, 40, 0), "R5 way3 kept", 1, 32'hC000_0004, 4'd0);
        look(mk(6, 40, 0), "R5 new entry", 1, 32'hC000_0006, 4'd0);
    endtask

    task automatic t_bogus();
        upd(mk(1, 60, 4), 32'hD000_0001);
        upd(mk(2, 60, 8), 32'hD000_0002);
        upd(mk(1, 61, 4), 32'hD000_0003);
        @(negedge clk);
        bogus_valid = 1'b1; bogus_addr = mk(1, 60, 4);
        @(negedge clk);
        bogus_valid = 1'b0;
        look(mk(1, 60, 0), "R7 set wiped", 0, '0, '0);
        look(mk(2, 60, 0), "R7 set wiped", 0, '0, '0);
        look(mk(1, 61, 0), "R7 other set kept", 1, 32'hD000_0003, 4'd4);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = mk(7, 60, 1); upd_target = 32'hD000_0007;
        bogus_valid = 1'b1; bogus_addr = mk(9, 60, 0);
        @(negedge clk);
        upd_addr = mk(7, 62, 1); bogus_addr = mk(9, 63, 0);
        @(negedge clk);
        upd_valid = 1'b0; bogus_valid = 1'b0;
        look(mk(7, 60, 0), "R7 same-set update dropped", 0, '0, '0);
        look(mk(7, 62, 0), "R7 other-set update kept", 1, 32'hD000_0007, 4'd1);
    endtask

    task automatic t_random();
        bit eh; logic [31:0] et; logic [3:0] eo;
        do_reset();
        look(mk(1, 61, 0), "R8 reset clears entries", 0, '0, '0);
        m_clear();
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ua, ba, ut;
            int op;
            op = int'($urandom % 10);
            ua = mk(int'($urandom % 6), 5 + int'($urandom % 2), int'($urandom % 16));
            ba = mk(int'($urandom % 6), 5 + int'($urandom % 2), int'($urandom % 16));
            ut = $urandom;
            @(negedge clk);
            upd_valid   = (op < 6);
            bogus_valid = (op == 6) || (op == 7 && i % 3 == 0);
            upd_addr = ua; upd_target = ut; bogus_addr = ba;
            fetch_addr = mk(int'($urandom % 6), 5 + int'($urandom % 2), int'($urandom % 16));
            #1;
            m_look(fetch_addr, eh, et, eo);
            expect_out("R3 R4 R5 R6 R7 random vs model", eh, et, eo);
            if (upd_valid && !(bogus_valid && ba[12:4] == ua[12:4])) m_update(ua, ut);
            if (bogus_valid)
                for (int w = 0; w < 4; w++) m_v[int'(ba[12:4])][w] = 0;
        end
        @(negedge clk);
        upd_valid = 1'b0; bogus_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic();
        t_multi();
        t_plru();
        t_bogus();
        t_random();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, got no completion, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule